// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Capture Strobe

This block presents a latched five-digit decimal result on a shared 4-bit BCD bus, one digit at a time. It drives one active-high select line per digit, so a multiplexed display keeps refreshing. An end-of-conversion pulse loads a new result and an overrange flag, and restarts the scan at the most significant digit. Scanning then runs from the most significant digit to the least significant one and repeats.

During the first pass after each new result, an active-low capture strobe marks the middle of every digit slot. A UART, processor or external latch can use it to pick up each digit. Later passes refresh the display but send no strobe.

An overrange result forces the data bus to zero. It also darkens every select line from the last strobe until the next reference-integrate start pulse. Scanning then resumes, strobe-free, so the display blinks.

Time is kept in counts. One count is two cycles of the block clock, and a phase bit marks which half of the count is current. This gives a half-count strobe with a single clock edge.

Top module: `bcd_digit_scanner`

## Requirements
- R1: When lit, `digit_sel_o` is one-hot. The scan goes from bit 4 (most significant digit) down to bit 0 and then wraps back to bit 4, continuously.
- R2: One count is two `clk` cycles. The first slot of a scan lasts DIGIT_COUNTS+LEAD_EXTRA counts (201 by default); every other slot lasts DIGIT_COUNTS counts (200).
- R3: In the cycle after `eoc_i` is sampled high, bit 4 of `digit_sel_o` is lit. Each conversion gives exactly five strobe pulses, all in the first scan; later scans give none.
- R4: `strobe_n_o` goes low for exactly one `clk` cycle (half a count), at the start of a count. For the first slot this is count STROBE_OFFSET+LEAD_EXTRA (101) of the slot; for the other slots it is count STROBE_OFFSET (100).
- R5: `bcd_o` shows the latched digit of the lit slot. It changes together with the select lines. Digit i of `result_i` sits at bits [4i+3:4i], digit 4 being the most significant.
- R6: When the latched overrange flag is set, `bcd_o` is 0 in every cycle.
- R7: With overrange latched, all select lines go low in the cycle after the final strobe cycle. They stay low until `ref_start_i` is sampled high. Scanning then restarts at the most significant digit with no strobe.
- R8: `ref_start_i` has no effect on any output unless the display is blanked by overrange.
- R9: After reset and until the first `eoc_i`, all select lines are low, `bcd_o` is 0 and `strobe_n_o` is high.
- R10: An `eoc_i` in the middle of a scan restarts it at the most significant digit with no overlapping selects. `eoc_i` takes priority over a `ref_start_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two cycles per count |
| rst | input | 1 | Synchronous active-high reset |
| eoc_i | input | 1 | End-of-conversion pulse; loads result and overrange |
| result_i | input | 20 | Five BCD digits, most significant in bits [19:16] |
| ovr_i | input | 1 | Overrange flag of the result, sampled with eoc_i |
| ref_start_i | input | 1 | Start of the next reference integrate; ends overrange blanking |
| digit_sel_o | output | 5 | Active-high digit selects, bit 4 most significant |
| bcd_o | output | 4 | Shared BCD data of the lit digit |
| strobe_n_o | output | 1 | Active-low capture strobe |

## Verification
The bench goes after slot widths that are off by one count: a first slot of 200 counts, or a strobe at count 100 in that slot, would shift every later edge by two cycles. It also checks strobe re-arming. A design that strobes on every scan, or never re-arms on a new end-of-conversion, fails the five-per-conversion tally.

The overrange cases follow. A late or early blank shows as a lit D1 in the wrong cycle. A reference-integrate pulse that acts when no blank is pending would restart the scan visibly. A design that blanks again after the resumed scan would darken a display that must stay lit. Finally, the bench fires end-of-conversion in the middle of a scan and together with a reference pulse, to expose overlapping selects or the wrong priority.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

    localparam int unsigned BCD_W = 4;

    typedef logic [BCD_W-1:0] bcd_t;

    // Strobe and display-blank state
    typedef struct packed {
        logic armed;   // strobes still to be sent in this conversion
        logic blank;   // select lines forced dark
    } strobe_state_t;

    // Slot length in counts; the leading slot is widened
    function automatic int unsigned slot_len(logic is_lead, int unsigned base,
                                             int unsigned extra);
        return is_lead ? base + extra : base;
    endfunction

    // Count inside a slot at which the strobe is issued
    function automatic int unsigned strobe_at(logic is_lead, int unsigned offset,
                                              int unsigned extra);
        return is_lead ? offset + extra : offset;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
    import bcd_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS   = 5,
    parameter int unsigned DIGIT_COUNTS = 200,
    parameter int unsigned LEAD_EXTRA   = 1,
    localparam int unsigned IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
    localparam int unsigned CNT_W = $clog2(DIGIT_COUNTS + LEAD_EXTRA)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [IDX_W-1:0] idx_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             phase_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    logic [CNT_W-1:0] len_m1;

    always_comb begin
        len_m1 = CNT_W'(slot_len(idx_q == '0, DIGIT_COUNTS, LEAD_EXTRA) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            idx_q   <= '0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                if (cnt_q == len_m1) begin
                    cnt_q <= '0;
                    idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign idx_o   = idx_q;
    assign cnt_o   = cnt_q;
    assign phase_o = phase_q;

    AST_CNT_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= len_m1); // R2
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase_q && cnt_q == len_m1 && !restart) |=> (cnt_q == '0 && idx_q != $past(idx_q))); // R1
    AST_HALF_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!phase_q && !restart) |=> ($stable(cnt_q) && $stable(idx_q))); // R2

endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
    import bcd_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS    = 5,
    parameter int unsigned DIGIT_COUNTS  = 200,
    parameter int unsigned LEAD_EXTRA    = 1,
    parameter int unsigned STROBE_OFFSET = 100,
    localparam int unsigned IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
    localparam int unsigned CNT_W = $clog2(DIGIT_COUNTS + LEAD_EXTRA)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eoc,
    input  logic             ref_start,
    input  logic             ovr_q,
    input  logic [IDX_W-1:0] idx,
    input  logic [CNT_W-1:0] cnt,
    input  logic             phase,
    output logic             strobe_n,
    output logic             blank,
    output logic             resume
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

    strobe_state_t st_q, st_d;
    logic          hit;
    logic          final_hit;

    always_comb begin
        hit       = !phase && (cnt == CNT_W'(strobe_at(idx == '0, STROBE_OFFSET, LEAD_EXTRA)));
        final_hit = st_q.armed && hit && (idx == LAST_IDX);
        resume    = ref_start && !eoc && st_q.blank && ovr_q;
        strobe_n  = !(st_q.armed && hit);
        blank     = st_q.blank;
    end

    always_comb begin
        st_d = st_q;
        if (eoc) begin
            st_d.armed = 1'b1;
            st_d.blank = 1'b0;
        end else if (resume) begin
            st_d.blank = 1'b0;
        end else if (final_hit) begin
            st_d.armed = 1'b0;
            st_d.blank = ovr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.armed <= 1'b0;
            st_q.blank <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |=> strobe_n); // R4
    AST_EOC_ARMS: assert property (@(posedge clk) disable iff (rst)
        eoc |=> (st_q.armed && !st_q.blank)); // R3
    AST_BLANK_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.blank) |-> $past(!strobe_n)); // R7
    AST_NO_STROBE_DARK: assert property (@(posedge clk) disable iff (rst)
        st_q.blank |-> strobe_n); // R9

endmodule

// File: rtl/digit_out.sv
module digit_out
    import bcd_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS = 5,
    localparam int unsigned IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1,
    localparam int unsigned DATA_W = NUM_DIGITS * BCD_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  eoc,
    input  logic [DATA_W-1:0]     result_i,
    input  logic                  ovr_i,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  blank,
    output logic [NUM_DIGITS-1:0] digit_sel_o,
    output bcd_t                  bcd_o,
    output logic                  ovr_q
);

    logic [NUM_DIGITS-1:0][BCD_W-1:0] digits_q;
    bcd_t                             picked;

    always_ff @(posedge clk) begin
        if (rst) begin
            digits_q <= '0;
            ovr_q    <= 1'b0;
        end else if (eoc) begin
            digits_q <= result_i;
            ovr_q    <= ovr_i;
        end
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
        assign digit_sel_o[NUM_DIGITS-1-g] = !blank && (idx == IDX_W'(g));
    end

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (idx == IDX_W'(k)) picked = digits_q[NUM_DIGITS-1-k];
        end
        bcd_o = (blank || ovr_q) ? '0 : picked;
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_sel_o)); // R1
    AST_OVR_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> (bcd_o == '0)); // R6
    AST_DARK_WHEN_BLANK: assert property (@(posedge clk) disable iff (rst)
        blank |-> (digit_sel_o == '0)); // R7
    AST_EOC_LEADS: assert property (@(posedge clk) disable iff (rst)
        eoc |=> digit_sel_o[NUM_DIGITS-1]); // R10

endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner
    import bcd_scan_pkg::*;
#(
    parameter int unsigned NUM_DIGITS    = 5,
    parameter int unsigned DIGIT_COUNTS  = 200,
    parameter int unsigned LEAD_EXTRA    = 1,
    parameter int unsigned STROBE_OFFSET = 100
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          eoc_i,
    input  logic [NUM_DIGITS*BCD_W-1:0]   result_i,
    input  logic                          ovr_i,
    input  logic                          ref_start_i,
    output logic [NUM_DIGITS-1:0]         digit_sel_o,
    output logic [BCD_W-1:0]              bcd_o,
    output logic                          strobe_n_o
);

    localparam int unsigned IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam int unsigned CNT_W = $clog2(DIGIT_COUNTS + LEAD_EXTRA);

    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             phase;
    logic             blank;
    logic             resume;
    logic             ovr_q;
    logic             restart;

    assign restart = eoc_i || resume;

    scan_timer #(
        .NUM_DIGITS  (NUM_DIGITS),
        .DIGIT_COUNTS(DIGIT_COUNTS),
        .LEAD_EXTRA  (LEAD_EXTRA)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .idx_o  (idx),
        .cnt_o  (cnt),
        .phase_o(phase)
    );

    strobe_gen #(
        .NUM_DIGITS   (NUM_DIGITS),
        .DIGIT_COUNTS (DIGIT_COUNTS),
        .LEAD_EXTRA   (LEAD_EXTRA),
        .STROBE_OFFSET(STROBE_OFFSET)
    ) i_strobe (
        .clk      (clk),
        .rst      (rst),
        .eoc      (eoc_i),
        .ref_start(ref_start_i),
        .ovr_q    (ovr_q),
        .idx      (idx),
        .cnt      (cnt),
        .phase    (phase),
        .strobe_n (strobe_n_o),
        .blank    (blank),
        .resume   (resume)
    );

    digit_out #(
        .NUM_DIGITS(NUM_DIGITS)
    ) i_out (
        .clk        (clk),
        .rst        (rst),
        .eoc        (eoc_i),
        .result_i   (result_i),
        .ovr_i      (ovr_i),
        .idx        (idx),
        .blank      (blank),
        .digit_sel_o(digit_sel_o),
        .bcd_o      (bcd_o),
        .ovr_q      (ovr_q)
    );

    AST_STROBE_IN_LIT_SLOT: assert property (@(posedge clk) disable iff (rst)
        !strobe_n_o |-> (digit_sel_o != '0)); // R4
    AST_RESUME_AT_LEAD: assert property (@(posedge clk) disable iff (rst)
        (ref_start_i && !eoc_i && blank && ovr_q) |=> digit_sel_o[NUM_DIGITS-1]); // R7

endmodule

// File: tb/test_bcd_digit_scanner.sv
module test_bcd_digit_scanner;

    localparam int ND = 5;
    localparam int DC = 200;
    localparam int LX = 1;
    localparam int SO = 100;
    localparam int SCAN = ND * DC + LX;
    localparam int FINAL_S = 2 * (SCAN - DC + SO);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            eoc = 1'b0;
    logic [ND*4-1:0] result = '0;
    logic            ovr = 1'b0;
    logic            ref_start = 1'b0;
    logic [ND-1:0]   digit_sel;
    logic [3:0]      bcd;
    logic            strobe_n;

    int n_cmp = 0;
    int n_bad = 0;
    int strobe_seen = 0;
    bit started = 0;
    bit done = 0;

    // bench model state
    int            m_s = 0;
    int            m_mode = 0;  // 0 dark, 1 after eoc, 2 after resume
    bit            m_ovr = 0;
    logic [ND*4-1:0] m_data = '0;

    always #5 clk = ~clk;

    bcd_digit_scanner i_bcd_digit_scanner (
        .clk        (clk),
        .rst        (rst),
        .eoc_i      (eoc),
        .result_i   (result),
        .ovr_i      (ovr),
        .ref_start_i(ref_start),
        .digit_sel_o(digit_sel),
        .bcd_o      (bcd),
        .strobe_n_o (strobe_n)
    );

    function automatic bit exp_blank();
        return (m_mode == 0) || (m_mode == 1 && m_ovr && m_s >= FINAL_S + 1);
    endfunction

    function automatic int exp_idx();
        int pos = (m_s / 2) % SCAN;
        if (pos < DC + LX) return 0;
        return 1 + (pos - DC - LX) / DC;
    endfunction

    function automatic int exp_off();
        int pos = (m_s / 2) % SCAN;
        if (pos < DC + LX) return pos;
        return (pos - DC - LX) % DC;
    endfunction

    function automatic logic [ND-1:0] exp_sel();
        if (exp_blank()) return '0;
        return ND'(1) << (ND - 1 - exp_idx());
    endfunction

    function automatic logic [3:0] exp_bcd();
        if (exp_blank() || m_ovr) return 4'd0;
        return m_data[(ND - 1 - exp_idx()) * 4 +: 4];
    endfunction

    function automatic logic exp_strobe_n();
        int tgt = (exp_idx() == 0) ? SO + LX : SO;
        if (m_mode == 1 && (m_s / 2) < SCAN && (m_s % 2) == 0 && exp_off() == tgt)
            return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [ND*4-1:0] rand_bcd();
        logic [ND*4-1:0] v;
        for (int i = 0; i < ND; i++) v[i*4 +: 4] = 4'($urandom % 10);
        return v;
    endfunction

    // model advances with the design clock
    always @(posedge clk) begin
        if (rst) begin
            m_s = 0; m_mode = 0; m_ovr = 0; m_data = '0;
        end else if (eoc) begin
            m_s = 0; m_mode = 1; m_ovr = ovr; m_data = result;
        end else if (ref_start && m_ovr && exp_blank()) begin
            m_s = 0; m_mode = 2;
        end else begin
            m_s = m_s + 1;
        end
        started = 1;
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            n_cmp += 3;
            if (digit_sel !== exp_sel()) begin
                n_bad++;
                $display("FAIL %s digit_sel s=%0d actual=%b expected=%b",
                         exp_blank() ? "R7" : "R2", m_s, digit_sel, exp_sel());
            end
            if (bcd !== exp_bcd()) begin
                n_bad++;
                $display("FAIL %s bcd s=%0d actual=%h expected=%h",
                         m_ovr ? "R6" : "R5", m_s, bcd, exp_bcd());
            end
            if (strobe_n !== exp_strobe_n()) begin
                n_bad++;
                $display("FAIL R4 strobe_n s=%0d actual=%b expected=%b",
                         m_s, strobe_n, exp_strobe_n());
            end
            if (strobe_n === 1'b0) strobe_seen++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire_eoc(input logic [ND*4-1:0] d, input bit o, input bit with_ref);
        @(negedge clk);
        eoc = 1'b1; result = d; ovr = o; ref_start = with_ref;
        @(negedge clk);
        eoc = 1'b0; ref_start = 1'b0; ovr = $urandom % 2;
    endtask

    task automatic fire_ref();
        @(negedge clk);
        ref_start = 1'b1;
        @(negedge clk);
        ref_start = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7351));
        idle(4);
        rst = 1'b0;
        idle(3);
        // R9: dark after reset
        check(digit_sel == '0 && bcd == 4'd0 && strobe_n == 1'b1, "R9 reset outputs",
              int'(digit_sel), 0);
        // R8: reference pulse while nothing is blanked by overrange
        fire_ref();
        idle(2);
        check(digit_sel == '0, "R8 ref_start in dark state", int'(digit_sel), 0);

        // R3: five strobes in the first scan, none in the next two
        strobe_seen = 0;
        fire_eoc(20'h12345, 1'b0, 1'b0);
        check(digit_sel == 5'b10000, "R3 lead digit after eoc", int'(digit_sel), 16);
        idle(3 * 2 * SCAN);
        check(strobe_seen == 5, "R3 strobes per conversion", strobe_seen, 5);
        // R8: ref_start during a lit scan changes nothing
        strobe_seen = 0;
        fire_ref();
        idle(2 * SCAN);
        check(strobe_seen == 0, "R8 no strobe after ref_start", strobe_seen, 0);

        // R7: overrange blanks after final strobe, resumes on ref_start
        strobe_seen = 0;
        fire_eoc(20'h98765, 1'b1, 1'b0);
        idle(FINAL_S + 40);
        check(digit_sel == '0, "R7 dark after final strobe", int'(digit_sel), 0);
        check(strobe_seen == 5, "R7 five strobes before blank", strobe_seen, 5);
        idle(3000);
        check(digit_sel == '0, "R7 still dark", int'(digit_sel), 0);
        fire_ref();
        check(digit_sel == 5'b10000, "R7 resume at lead digit", int'(digit_sel), 16);
        check(bcd == 4'd0, "R6 data zero on overrange", int'(bcd), 0);
        strobe_seen = 0;
        idle(3 * 2 * SCAN);
        check(strobe_seen == 0 && digit_sel != '0, "R7 resumed scan lit, no strobe",
              strobe_seen, 0);

        // R10: restart mid-scan, and eoc together with ref_start
        fire_eoc(20'h55555, 1'b0, 1'b0);
        idle(700);
        fire_eoc(20'h01234, 1'b0, 1'b1);
        check(digit_sel == 5'b10000, "R10 restart mid-scan", int'(digit_sel), 16);
        check(bcd == 4'd0, "R5 lead digit data", int'(bcd), 0);
        idle(2 * (DC + LX) + 2);
        check(digit_sel == 5'b01000 && bcd == 4'd1, "R1 second digit", int'(bcd), 1);

        // random conversions
        for (int it = 0; it < 28; it++) begin
            int wait_n;
            fire_eoc(rand_bcd(), ($urandom % 3) == 0, ($urandom % 8) == 0);
            wait_n = 300 + int'($urandom % 4700);
            for (int c = 0; c < wait_n; c++) begin
                @(negedge clk);
                ref_start = (($urandom % 500) == 0);
            end
            @(negedge clk);
            ref_start = 1'b0;
        end
        idle(10);
        finish_run();
    end

endmodule